// File: doc/BRIEF.md
# Ping-Pong Two-Bank Transfer Buffer

This block carries 16-bit words from a producer bus to a consumer bus through two storage banks of four words each. The producer writes into whichever bank currently belongs to it. The consumer reads from whichever bank currently belongs to it. Ownership changes one whole bank at a time. Each bank has its own full flag. A write pointer and a read pointer walk through the words of the owned banks.

When the producer completes a bank while the other bank is empty, the two banks trade roles. The block then emits a one-cycle data-available pulse, so that a consumer-side DMA engine that stalled for lack of data can resume. A write that meets a full bank is dropped. A read from a bank that is not flagged full is still served, but it raises an underrun status pulse.

Both strobes are single-cycle and synchronous to one clock. When they fall in the same cycle, the read is resolved against the state held before that edge. The write is then applied to the state that the read leaves behind.

Top module: `pp_xfer_fifo`

## Requirements
- R1: After a synchronous reset both full flags are 0, both pointers are 0, and both `wr_bank` and `rd_bank` are 0 (bank A; bank B is 1). `data_avail`, `underrun` and `rd_data` are 0.
- R2: A write strobe while the current write bank is flagged full is discarded. It changes no stored word, no pointer, no flag and no bank assignment.
- R3: An accepted write stores the word at the write pointer of the write bank and increments the pointer. The write that reaches the fourth word sets that bank's bit in `bank_full` (bit 0 for A, bit 1 for B) and returns the pointer to 0.
- R4: When a write fills its bank and the other bank is not full, the filled bank becomes the read bank and the other bank becomes the write bank. `data_avail` is 1 in the cycle after that write edge.
- R5: When a write fills its bank and the other bank is already full, both bank assignments are kept and `data_avail` stays 0.
- R6: A read strobe returns, on `rd_data` one cycle later, the word at the read pointer of the read bank, and increments the pointer. Words come out of a bank in the order they were written. The fourth read of a bank clears its full flag and returns the pointer to 0.
- R7: When a bank is drained and the other bank is full, the other bank becomes the read bank and the drained bank becomes the write bank.
- R8: A read from a bank whose full flag is clear still returns the stored word and advances the pointer. `underrun` is 1 in the cycle after that read edge, and 0 after any other edge.
- R9: `data_avail` is a single-cycle pulse and is never high in two consecutive cycles.
- R10: When a read and a write happen in the same cycle, the read uses the pre-edge state (a read-first memory returns the old word). The write then applies to the state after the read, including a bank swap caused by that read.
- R11: `rd_data` holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Producer write strobe, one cycle per word |
| wr_data | input | 16 | Producer word |
| rd_en | input | 1 | Consumer read strobe, one cycle per word |
| rd_data | output | 16 | Word returned by the last read (registered) |
| data_avail | output | 1 | One-cycle pulse: a filled bank was handed to the consumer |
| underrun | output | 1 | One-cycle pulse: the last read hit a bank not flagged full |
| bank_full | output | 2 | Full flags, bit 0 bank A, bit 1 bank B |
| wr_bank | output | 1 | Bank currently owned by the producer (0 = A) |
| rd_bank | output | 1 | Bank currently owned by the consumer (0 = A) |

## Verification
A read and a write can land on the same edge. The case that matters is a read that drains the read bank, and so swaps the banks, in the same cycle as a write. That write must land in the bank the read just released. The reverse case matters too: a write that fills a bank while the consumer is still reading the other one. The bench provokes both cases with directed sequences that first fill both banks and then strobe both sides together. It adds a long pseudo-random stretch in which the two strobes are independent. The behavioural model applies the read first and the write second, and every output is compared with the model after each edge.

// File: rtl/pp_fifo_pkg.sv
package pp_fifo_pkg;
  typedef logic bank_t;

  localparam bank_t BANK_A = 1'b0;
  localparam bank_t BANK_B = 1'b1;

  function automatic bank_t other_bank(input bank_t b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/pp_bank_ram.sv
module pp_bank_ram #(
  parameter int DATA_W = 16,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DATA_W-1:0] store [WORDS];

  // plain write port, inferable as block RAM
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // read-first registered port; old contents seen on same-address collision
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/pp_read_stage.sv
module pp_read_stage
  import pp_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic          rd_en,
  input  logic [1:0]    full_i,
  input  bank_t         wsel_i,
  input  bank_t         rsel_i,
  input  logic [PW-1:0] rptr_i,
  output logic [1:0]    full_o,
  output bank_t         wsel_o,
  output bank_t         rsel_o,
  output logic [PW-1:0] rptr_o,
  output logic          ram_re,
  output logic [PW:0]   ram_raddr,
  output logic          underrun_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  always_comb begin
    full_o     = full_i;
    wsel_o     = wsel_i;
    rsel_o     = rsel_i;
    rptr_o     = rptr_i;
    ram_re     = rd_en;
    ram_raddr  = {rsel_i, rptr_i};
    underrun_o = rd_en & ~full_i[rsel_i];
    if (rd_en) begin
      if (rptr_i == LAST) begin
        rptr_o         = '0;
        full_o[rsel_i] = 1'b0;
        if (full_i[other_bank(rsel_i)]) begin
          rsel_o = other_bank(rsel_i);
          wsel_o = rsel_i;
        end
      end else begin
        rptr_o = rptr_i + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pp_write_stage.sv
module pp_write_stage
  import pp_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic          wr_en,
  input  logic [1:0]    full_i,
  input  bank_t         wsel_i,
  input  bank_t         rsel_i,
  input  logic [PW-1:0] wptr_i,
  output logic [1:0]    full_o,
  output bank_t         wsel_o,
  output bank_t         rsel_o,
  output logic [PW-1:0] wptr_o,
  output logic          ram_we,
  output logic [PW:0]   ram_waddr,
  output logic          avail_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic accept;

  always_comb begin
    accept    = wr_en & ~full_i[wsel_i];
    full_o    = full_i;
    wsel_o    = wsel_i;
    rsel_o    = rsel_i;
    wptr_o    = wptr_i;
    avail_o   = 1'b0;
    ram_we    = accept;
    ram_waddr = {wsel_i, wptr_i};
    if (accept) begin
      if (wptr_i == LAST) begin
        wptr_o         = '0;
        full_o[wsel_i] = 1'b1;
        if (!full_i[other_bank(wsel_i)]) begin
          rsel_o  = wsel_i;
          wsel_o  = other_bank(wsel_i);
          avail_o = 1'b1;
        end
      end else begin
        wptr_o = wptr_i + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pp_xfer_fifo.sv
module pp_xfer_fifo
  import pp_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_avail,
  output logic              underrun,
  output logic [1:0]        bank_full,
  output logic              wr_bank,
  output logic              rd_bank
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int AW = PW + 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  // registered state
  logic [1:0]    full_q;
  bank_t         wsel_q, rsel_q;
  logic [PW-1:0] wptr_q, rptr_q;
  logic          avail_q, under_q;

  // after the read step
  logic [1:0]    full_r;
  bank_t         wsel_r, rsel_r;
  logic [PW-1:0] rptr_r;
  logic          ram_re, under_r;
  logic [AW-1:0] ram_raddr;

  // after the write step
  logic [1:0]    full_w;
  bank_t         wsel_w, rsel_w;
  logic [PW-1:0] wptr_w;
  logic          ram_we, avail_w;
  logic [AW-1:0] ram_waddr;

  pp_read_stage #(.DEPTH(DEPTH), .PW(PW)) u_rd (
    .rd_en(rd_en), .full_i(full_q), .wsel_i(wsel_q), .rsel_i(rsel_q),
    .rptr_i(rptr_q), .full_o(full_r), .wsel_o(wsel_r), .rsel_o(rsel_r),
    .rptr_o(rptr_r), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .underrun_o(under_r)
  );

  pp_write_stage #(.DEPTH(DEPTH), .PW(PW)) u_wr (
    .wr_en(wr_en), .full_i(full_r), .wsel_i(wsel_r), .rsel_i(rsel_r),
    .wptr_i(wptr_q), .full_o(full_w), .wsel_o(wsel_w), .rsel_o(rsel_w),
    .wptr_o(wptr_w), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .avail_o(avail_w)
  );

  pp_bank_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .we(ram_we), .waddr(ram_waddr), .wdata(wr_data),
    .re(ram_re), .raddr(ram_raddr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= '0;
      wsel_q  <= BANK_A;
      rsel_q  <= BANK_A;
      wptr_q  <= '0;
      rptr_q  <= '0;
      avail_q <= 1'b0;
      under_q <= 1'b0;
    end else begin
      full_q  <= full_w;
      wsel_q  <= wsel_w;
      rsel_q  <= rsel_w;
      wptr_q  <= wptr_w;
      rptr_q  <= rptr_r;
      avail_q <= avail_w;
      under_q <= under_r;
    end
  end

  assign data_avail = avail_q;
  assign underrun   = under_q;
  assign bank_full  = full_q;
  assign wr_bank    = wsel_q;
  assign rd_bank    = rsel_q;

  // R1: state after reset
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (full_q == 2'b00 && wptr_q == '0 && rptr_q == '0 &&
             wsel_q == BANK_A && rsel_q == BANK_A && !avail_q && !under_q));

  // R2: write to a full bank leaves the producer side untouched
  assert_drop_full_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && full_q[wsel_q]) |=>
      ($stable(wptr_q) && $stable(full_q) && $stable(wsel_q) && !avail_q));

  // R4: fill with other bank empty hands the bank over and pulses
  assert_fill_swap_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && !full_q[wsel_q] && wptr_q == LAST &&
     !full_q[other_bank(wsel_q)]) |=>
      (avail_q && rsel_q == $past(wsel_q) && wsel_q != $past(wsel_q)));

  // R5: fill with other bank full keeps assignments, no pulse
  assert_fill_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && !full_q[wsel_q] && wptr_q == LAST &&
     full_q[other_bank(wsel_q)]) |=>
      (!avail_q && $stable(wsel_q) && $stable(rsel_q) && full_q == 2'b11));

  // R7: drain with other bank full swaps roles
  assert_drain_swap_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && rptr_q == LAST && full_q[other_bank(rsel_q)]) |=>
      (rsel_q != $past(rsel_q) && wsel_q == $past(rsel_q) &&
       rptr_q == '0));

  // R8: read from a bank not flagged full reports underrun
  assert_underrun_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !full_q[rsel_q]) |=> under_q);

  // R9: data-available never lasts two cycles
  assert_avail_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    avail_q |=> !avail_q);

  // R11: read data holds without a read strobe
  assert_hold_data_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/sim_pp_xfer_fifo.sv
module sim_pp_xfer_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        data_avail, underrun, wr_bank, rd_bank;
  logic [1:0]  bank_full;

  int errors = 0;
  int checks = 0;

  // behavioural reference model
  int  m_mem [8];
  bit  m_known [8];
  bit  m_full [2];
  int  m_ws, m_rs, m_wp, m_rp;
  int  e_rd;
  bit  e_rd_known;
  bit  e_av, e_un;

  pp_xfer_fifo u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .data_avail(data_avail), .underrun(underrun),
    .bank_full(bank_full), .wr_bank(wr_bank), .rd_bank(rd_bank)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int got,
                       input int exp, input string ph);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s (%s): got %0h expected %0h", req, what, ph, got, exp);
    end
  endtask

  task automatic model_reset();
    m_full[0] = 0; m_full[1] = 0;
    m_ws = 0; m_rs = 0; m_wp = 0; m_rp = 0;
    e_rd = 0; e_rd_known = 1; e_av = 0; e_un = 0;
  endtask

  task automatic compare(input string ph);
    if (e_rd_known) check("R6", "rd_data", rd_data, e_rd, ph);
    check("R4", "data_avail", data_avail, e_av, ph);
    check("R8", "underrun", underrun, e_un, ph);
    check("R3", "bank_full", bank_full, {m_full[1], m_full[0]}, ph);
    check("R7", "wr_bank", wr_bank, m_ws, ph);
    check("R7", "rd_bank", rd_bank, m_rs, ph);
  endtask

  // one clock: drive at negedge, step model (read then write), compare after edge
  task automatic cyc(input bit w, input int d, input bit r, input string ph);
    @(negedge clk);
    wr_en = w; wr_data = 16'(d); rd_en = r;
    e_av = 0; e_un = 0;
    if (r) begin
      e_un = !m_full[m_rs];
      e_rd = m_mem[m_rs*DEPTH + m_rp];
      e_rd_known = m_known[m_rs*DEPTH + m_rp];
      m_rp++;
      if (m_rp == DEPTH) begin
        m_rp = 0;
        m_full[m_rs] = 0;
        if (m_full[1-m_rs]) begin m_ws = m_rs; m_rs = 1 - m_rs; end
      end
    end
    if (w && !m_full[m_ws]) begin
      m_mem[m_ws*DEPTH + m_wp] = d & 16'hffff;
      m_known[m_ws*DEPTH + m_wp] = 1;
      m_wp++;
      if (m_wp == DEPTH) begin
        m_wp = 0;
        m_full[m_ws] = 1;
        if (!m_full[1-m_ws]) begin m_rs = m_ws; m_ws = 1 - m_ws; e_av = 1; end
      end
    end
    @(posedge clk);
    #1;
    compare(ph);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_en = 0; rd_en = 0; wr_data = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    check("R1", "bank_full", bank_full, 0, "reset");
    check("R1", "wr_bank", wr_bank, 0, "reset");
    check("R1", "rd_bank", rd_bank, 0, "reset");
    check("R1", "data_avail", data_avail, 0, "reset");
    check("R1", "underrun", underrun, 0, "reset");
    check("R1", "rd_data", rd_data, 0, "reset");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_known[i] = 0; m_mem[i] = 0; end
    rst = 1; wr_en = 0; rd_en = 0; wr_data = '0;
    do_reset();

    // R3/R4: fill bank A, expect hand-over and pulse
    for (int i = 0; i < DEPTH; i++) cyc(1, 16'h1100 + i, 0, "R3 fill A");
    // R9: pulse gone next cycle
    cyc(0, 0, 0, "R9 pulse end");
    check("R9", "data_avail low", data_avail, 0, "R9 pulse end");
    // R5: fill bank B while A full
    for (int i = 0; i < DEPTH; i++) cyc(1, 16'h2200 + i, 0, "R5 fill B");
    // R2: writes to full bank dropped
    for (int i = 0; i < 3; i++) cyc(1, 16'hdead, 0, "R2 drop");
    // R6/R7: drain A in order, then B takes over
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, "R6 drain A");
    check("R7", "rd_bank after drain", rd_bank, 1, "R7 swap");
    check("R7", "wr_bank after drain", wr_bank, 0, "R7 swap");
    // R11: hold
    cyc(0, 0, 0, "R11 hold");
    cyc(0, 0, 0, "R11 hold");
    // R10: refill A while draining B, simultaneous strobes
    for (int i = 0; i < DEPTH; i++) cyc(1, 16'h3300 + i, 1, "R10 both");
    // R10: fill B so both full, then drain and write in the same cycle
    for (int i = 0; i < DEPTH; i++) cyc(1, 16'h4400 + i, 0, "R10 prep");
    for (int i = 0; i < DEPTH; i++) cyc(1, 16'h5500 + i, 1, "R10 drain+write");
    for (int i = 0; i < 2 * DEPTH; i++) cyc(0, 0, 1, "R10 readout");
    // R8: underrun reads on empty banks
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 1, "R8 underrun");

    // mid-run reset
    cyc(1, 16'h7777, 0, "pre-reset");
    do_reset();

    // pseudo-random stretch
    begin
      int s;
      s = 32'h1ace;
      for (int n = 0; n < 4000; n++) begin
        s = (s * 1103515245 + 12345) & 32'h7fffffff;
        cyc(((s >> 8) % 3) != 0, (s >> 4) & 16'hffff, ((s >> 12) % 3) == 0,
            "R10 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule